// File: doc/BRIEF.md
# Segment ID Multiplicative Scrambler

This block maps a 36-bit proto segment identifier onto a scrambled virtual segment ID. It multiplies the proto ID by the fixed prime 200730139 and reduces the product modulo 2^36 − 1. Because the multiplier is co-prime with the modulus, every proto ID below the all-ones value gets its own distinct ID. The reduction uses no divider. The product's upper bits are folded onto its lower 36 bits, and then a single end-around correction brings the sum back into range.

The block builds the proto ID from the request itself. A kernel request takes the effective address with its 28 segment-offset bits dropped. A user request places the context above a 16-bit segment index, and that index comes from the same shifted address. Requests enter and results leave through valid/ready handshakes. Inside, a four-register pipeline runs with one shared advance enable, so a stalled output freezes every stage. The pipeline accepts one request per cycle.

Top module: `sid_scrambler`

## Requirements
- R1: For each accepted request, out_sid equals (proto × 200730139) mod (2^36 − 1), computed exactly and 36 bits wide.
- R2: When in_kernel is 1, the proto ID is in_ea[63:28]. The context input and in_ea[27:0] have no effect on the result.
- R3: When in_kernel is 0, the proto ID is (in_ctx << 16) | in_ea[43:28]. Address bits 63:44 and 27:0 have no effect on the result.
- R4: out_sid never carries the reserved all-ones value while out_valid is 1. An all-ones proto ID produces 0.
- R5: With out_ready held at 1, the result of a request accepted on rising edge k appears with out_valid = 1 right after edge k+3. Back-to-back requests give one result per cycle, in order.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_sid and out_valid hold. No result is lost, duplicated or reordered.
- R7: The synchronous active-high reset empties the pipeline. After reset, out_valid is 0 and in_ready is 1, and requests still in flight are discarded.
- R8: A proto ID of 0 gives 0. A proto ID of 1 gives 200730139. A proto ID of 2^36 − 2 gives the exactly reduced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge if in_valid is 1 |
| in_kernel | input | 1 | 1 selects the kernel proto form, 0 selects the user form |
| in_ctx | input | 19 | Context number used by user requests |
| in_ea | input | 64 | Effective address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_sid | output | 36 | Scrambled segment ID |

## Verification
The bench aims at the reduction boundaries: proto IDs 0, 1, 2^36 − 2 and the all-ones value. A design that drops the end-around correction returns 2^36 − 1 instead of 0 for all-ones. A design that folds wrongly is off by a multiple of the modulus near the top of the range. Kernel and user vectors carry noise in the address bits that must be ignored, which catches a wrong shift or a user index that is too wide. Streams with gaps and an irregular out_ready pattern expose stages that keep advancing during a stall: such a design loses or repeats results, or shows in_ready high while the output is blocked. A reset in mid-flight checks that stale results are flushed.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int SID_W_DEF     = 36;
  localparam int MULT_W_DEF    = 28;
  localparam int MULT_DEF      = 200730139;
  localparam int SEG_SHIFT_DEF = 28;
  localparam int ESID_W_DEF    = 16;
  localparam int CTX_W_DEF     = 19;
  localparam int EA_W_DEF      = 64;
  localparam int SPLIT_DEF     = 2;
  // Register stages from input to output
  localparam int LAT_DEF       = 4;
endpackage

// File: rtl/sid_proto_form.sv
module sid_proto_form #(
  parameter int EA_W      = sid_pkg::EA_W_DEF,
  parameter int CTX_W     = sid_pkg::CTX_W_DEF,
  parameter int SID_W     = sid_pkg::SID_W_DEF,
  parameter int SEG_SHIFT = sid_pkg::SEG_SHIFT_DEF,
  parameter int ESID_W    = sid_pkg::ESID_W_DEF
) (
  input  logic             kernel,
  input  logic [CTX_W-1:0] ctx,
  input  logic [EA_W-1:0]  ea,
  output logic [SID_W-1:0] proto
);
  // Segment number: address with the in-segment offset removed
  logic [SID_W-1:0] seg_num;
  logic [SID_W-1:0] user_form;

  assign seg_num   = ea[SEG_SHIFT +: SID_W];
  assign user_form = (SID_W'(ctx) << ESID_W) | SID_W'(seg_num[ESID_W-1:0]);
  assign proto     = kernel ? seg_num : user_form;

  // Offset bits never reach the identifier
  logic ea_unused_low;
  assign ea_unused_low = ^ea[SEG_SHIFT-1:0];
endmodule

// File: rtl/sid_mul_pipe.sv
module sid_mul_pipe #(
  parameter int SID_W  = sid_pkg::SID_W_DEF,
  parameter int MULT_W = sid_pkg::MULT_W_DEF,
  parameter logic [MULT_W-1:0] MULT = MULT_W'(sid_pkg::MULT_DEF),
  parameter int SPLIT  = sid_pkg::SPLIT_DEF,
  localparam int CHUNK_W = (SID_W + SPLIT - 1) / SPLIT,
  localparam int PAD_W   = CHUNK_W * SPLIT,
  localparam int PART_W  = CHUNK_W + MULT_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  input  logic                         in_vld,
  input  logic [SID_W-1:0]             in_proto,
  output logic                         out_vld,
  output logic [SPLIT-1:0][PART_W-1:0] out_parts
);
  logic             a_vld;
  logic [PAD_W-1:0] a_proto;
  logic             b_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld <= 1'b0;
      b_vld <= 1'b0;
    end else if (adv) begin
      a_vld <= in_vld;
      b_vld <= a_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) a_proto <= PAD_W'(in_proto);
  end

  // One narrow multiplier per chunk of the proto ID
  for (genvar g = 0; g < SPLIT; g++) begin : g_part
    logic [PART_W-1:0] part_q;
    always_ff @(posedge clk) begin
      if (adv) part_q <= PART_W'(a_proto[g*CHUNK_W +: CHUNK_W]) * PART_W'(MULT);
    end
    assign out_parts[g] = part_q;
  end

  assign out_vld = b_vld;
endmodule

// File: rtl/sid_fold_reduce.sv
module sid_fold_reduce #(
  parameter int SID_W  = sid_pkg::SID_W_DEF,
  parameter int MULT_W = sid_pkg::MULT_W_DEF,
  parameter int SPLIT  = sid_pkg::SPLIT_DEF,
  localparam int CHUNK_W = (SID_W + SPLIT - 1) / SPLIT,
  localparam int PART_W  = CHUNK_W + MULT_W,
  localparam int PROD_W  = SID_W + MULT_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  input  logic                         in_vld,
  input  logic [SPLIT-1:0][PART_W-1:0] in_parts,
  output logic                         out_vld,
  output logic [SID_W-1:0]             out_sid
);
  localparam logic [SID_W:0] MOD      = {1'b0, {SID_W{1'b1}}};
  localparam logic [SID_W:0] FOLD_MAX = MOD + ((SID_W+1)'(1) << (PROD_W - SID_W)) - (SID_W+1)'(1);

  logic [PROD_W-1:0] prod;
  logic [SID_W:0]    fold_d;
  logic [SID_W:0]    fold_q;
  logic              f_vld;
  logic              wrap;
  logic [SID_W-1:0]  res;

  always_comb begin
    prod = '0;
    for (int i = 0; i < SPLIT; i++)
      prod = prod + (PROD_W'(in_parts[i]) << (i * CHUNK_W));
  end

  // Fold: weight 2^SID_W is 1 modulo 2^SID_W - 1
  assign fold_d = (SID_W+1)'(prod[PROD_W-1:SID_W]) + (SID_W+1)'(prod[SID_W-1:0]);

  // Carry of fold+1 out of SID_W bits, i.e. fold reached the modulus
  assign wrap = (fold_q >= MOD);
  assign res  = fold_q[SID_W-1:0] + SID_W'(wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_vld   <= 1'b0;
      out_vld <= 1'b0;
    end else if (adv) begin
      f_vld   <= in_vld;
      out_vld <= f_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      fold_q  <= fold_d;
      out_sid <= res;
    end
  end

  // R1
  fold_range_chk: assert property (@(posedge clk) disable iff (rst)
    f_vld |-> (fold_q <= FOLD_MAX));

  // R4
  no_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_sid != MOD[SID_W-1:0]));
endmodule

// File: rtl/sid_scrambler.sv
module sid_scrambler #(
  parameter int EA_W      = sid_pkg::EA_W_DEF,
  parameter int CTX_W     = sid_pkg::CTX_W_DEF,
  parameter int SID_W     = sid_pkg::SID_W_DEF,
  parameter int SEG_SHIFT = sid_pkg::SEG_SHIFT_DEF,
  parameter int ESID_W    = sid_pkg::ESID_W_DEF,
  parameter int MULT_W    = sid_pkg::MULT_W_DEF,
  parameter logic [MULT_W-1:0] MULT = MULT_W'(sid_pkg::MULT_DEF),
  parameter int SPLIT     = sid_pkg::SPLIT_DEF,
  localparam int CHUNK_W  = (SID_W + SPLIT - 1) / SPLIT,
  localparam int PART_W   = CHUNK_W + MULT_W,
  localparam int LAT      = sid_pkg::LAT_DEF,
  localparam int OCC_W    = $clog2(LAT + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_kernel,
  input  logic [CTX_W-1:0] in_ctx,
  input  logic [EA_W-1:0]  in_ea,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SID_W-1:0] out_sid
);
  logic                         adv;
  logic [SID_W-1:0]             proto;
  logic                         mp_vld;
  logic [SPLIT-1:0][PART_W-1:0] mp_parts;

  // Whole pipe moves together unless the output is blocked
  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  sid_proto_form #(
    .EA_W(EA_W), .CTX_W(CTX_W), .SID_W(SID_W),
    .SEG_SHIFT(SEG_SHIFT), .ESID_W(ESID_W)
  ) u_proto (
    .kernel(in_kernel), .ctx(in_ctx), .ea(in_ea), .proto(proto)
  );

  sid_mul_pipe #(
    .SID_W(SID_W), .MULT_W(MULT_W), .MULT(MULT), .SPLIT(SPLIT)
  ) u_mul (
    .clk(clk), .rst(rst), .adv(adv), .in_vld(in_valid), .in_proto(proto),
    .out_vld(mp_vld), .out_parts(mp_parts)
  );

  sid_fold_reduce #(
    .SID_W(SID_W), .MULT_W(MULT_W), .SPLIT(SPLIT)
  ) u_red (
    .clk(clk), .rst(rst), .adv(adv), .in_vld(mp_vld), .in_parts(mp_parts),
    .out_vld(out_valid), .out_sid(out_sid)
  );

  // In-flight count, used only by the checks below
  logic [OCC_W-1:0] occ;
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else occ <= occ + OCC_W'(in_valid && in_ready) - OCC_W'(out_valid && out_ready);
  end

  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sid)));

  // R5
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(LAT));

  // R7
  empty_no_output_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> !out_valid);
endmodule

// File: tb/tb_sid_scrambler.sv
module tb_sid_scrambler;
  localparam int SID_W = 36;
  localparam int CTX_W = 19;
  localparam int EA_W  = 64;
  localparam logic [71:0] MULT = 72'd200730139;
  localparam logic [71:0] MOD  = (72'd1 << SID_W) - 72'd1;
  localparam int NV = 12;

  typedef struct packed {
    logic             kern;
    logic [CTX_W-1:0] ctx;
    logic [EA_W-1:0]  ea;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 19'h00000, 64'h0000_0000_0000_0000},  // proto 0 (R8)
    '{1'b1, 19'h7FFFF, 64'h0000_0000_1000_0000},  // proto 1, ctx ignored (R8, R2)
    '{1'b1, 19'h00000, 64'hFFFF_FFFF_F000_0000},  // all-ones proto (R4)
    '{1'b1, 19'h00000, 64'hFFFF_FFFF_E000_0000},  // 2^36-2 (R8)
    '{1'b1, 19'h00001, 64'hFFFF_FFFF_FFFF_FFFF},  // all-ones, offset noise (R4, R2)
    '{1'b1, 19'h2AAAA, 64'hC000_0000_1234_5678},  // kernel (R2)
    '{1'b1, 19'h00000, 64'h8765_4321_0FED_CBA9},  // kernel (R2)
    '{1'b0, 19'h00000, 64'h0000_0123_4000_0000},  // user ctx 0 (R3)
    '{1'b0, 19'h7FFFF, 64'h0000_0FFF_F000_0000},  // user max (R3)
    '{1'b0, 19'h00005, 64'hABCD_E000_1000_0000},  // upper noise ignored (R3)
    '{1'b0, 19'h12345, 64'h0000_0000_0FFF_FFFF},  // offset only (R3)
    '{1'b0, 19'h3C3C3, 64'h5555_5A5A_5555_5555}   // mixed (R3)
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_kernel = 1'b0;
  logic [CTX_W-1:0] in_ctx = '0;
  logic [EA_W-1:0]  in_ea = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [SID_W-1:0] out_sid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sid_scrambler dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kernel(in_kernel), .in_ctx(in_ctx), .in_ea(in_ea),
    .out_valid(out_valid), .out_ready(out_ready), .out_sid(out_sid)
  );

  function automatic logic [SID_W-1:0] ref_sid(vec_t v);
    logic [71:0] p;
    logic [71:0] prod;
    if (v.kern) p = 72'(v.ea[63:28]);
    else        p = (72'(v.ctx) << 16) | 72'(v.ea[43:28]);
    prod = p * MULT;
    return SID_W'(prod % MOD);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_vec(input vec_t v);
    in_kernel = v.kern;
    in_ctx    = v.ctx;
    in_ea     = v.ea;
  endtask

  // Streams the table; mode 1 adds input gaps and output back-pressure
  task automatic run_stream(input int mode);
    int idx_s = 0;
    int idx_r = 0;
    int cyc   = 0;
    while (idx_r < NV && cyc < 500) begin
      @(negedge clk);
      out_ready = (mode == 0) ? 1'b1 : (cyc % 3 != 0);
      in_valid  = (idx_s < NV) && (mode == 0 || cyc % 5 != 2);
      if (idx_s < NV) drive_vec(VECS[idx_s]);
      #1;
      if (out_valid && out_ready) begin
        check(out_sid == ref_sid(VECS[idx_r]), "R1/R2/R3/R4/R8 result",
              64'(out_sid), 64'(ref_sid(VECS[idx_r])));
        idx_r++;
      end
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R6 stall blocks input", 64'(in_ready), 64'd0);
      if (in_valid && in_ready) idx_s++;
      cyc++;
    end
    check(idx_r == NV, "R5/R6 all results delivered", 64'(idx_r), 64'(NV));
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check(out_valid == 1'b0, "R7 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R7 in_ready after reset", 64'(in_ready), 64'd1);

    // R5 latency: accepted at the edge after this negedge, result 3 edges later
    in_valid = 1'b1;
    drive_vec(VECS[1]);
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 1; n <= 3; n++) begin
      #1;
      check(out_valid == 1'b0, "R5 no early result", 64'(out_valid), 64'd0);
      @(negedge clk);
    end
    #1;
    check(out_valid == 1'b1, "R5 result on third edge", 64'(out_valid), 64'd1);
    check(out_sid == SID_W'(200730139), "R8 proto one", 64'(out_sid), 64'd200730139);
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R5 single result", 64'(out_valid), 64'd0);

    run_stream(0);
    run_stream(1);

    // R6 long stall: output must hold
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    drive_vec(VECS[5]);
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b1, "R6 held valid", 64'(out_valid), 64'd1);
    check(out_sid == ref_sid(VECS[5]), "R6 held value", 64'(out_sid), 64'(ref_sid(VECS[5])));
    check(in_ready == 1'b0, "R6 ready low", 64'(in_ready), 64'd0);
    out_ready = 1'b1;
    repeat (8) @(negedge clk);

    // R7 reset flushes requests in flight
    in_valid = 1'b1;
    drive_vec(VECS[6]);
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < 5; n++) begin
      #1;
      check(out_valid == 1'b0, "R7 flushed", 64'(out_valid), 64'd0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule